// File: doc/BRIEF.md
# Serial Boot-Mode Configuration Loader

This block runs while the chip is held in reset and reads its fundamental operating modes from a slow serial stream. It produces a mode clock, which is the master clock divided by a power of two (256 by default). It then samples one stream bit per mode-clock period, beginning with bit 0. The stream is 256 bits long. Seventeen of its low bits become mode fields: write address-to-data delay, output drive code, bus width, timer-interrupt disable, non-block write type, byte order, PLL multiplier code and block-write data-rate code. The remaining bits must be zero.

A load begins when the power-good input rises. Once the last bit has been taken in, the decoded fields are registered and held steady, and a valid flag asserts. An error flag reports a stream whose must-be-zero bits are not zero or whose fields hold a reserved code. Two sticky status flags watch how the reset inputs are sequenced. The first reports a cold reset released too soon after the stream was loaded. The second reports a warm reset released too soon after the cold reset. A warm reset by itself leaves the loaded configuration untouched.

Top module: `boot_mode_loader`

## Requirements
- R1: `mode_clk` has a period of 2^DIV_LOG2 master clocks and is high for half of that period. It falls on the clock edge where `mode_din` is sampled, and that edge comes 3 master clocks before the bit period ends.
- R2: A rising edge of `pwr_good` starts a load and clears `cfg_valid`. The first sample edge after the start takes stream bit 0, and each following sample edge takes the next bit. `cfg_valid` rises one clock after the edge that samples bit 255.
- R3: The stream bits map to the fields as follows: bits 17:15 go to `wr_delay`, bits 14:13 to `drive_code`, bit 12 to `bus_32` (1 selects 32-bit), and bit 11 to `timer_int_off` (1 disables the timer interrupt).
- R4: The remaining fields are mapped as follows: bits 10:9 go to `nbw_type` (00 legacy, 01 reserved, 10 pipelined, 11 re-issue), bit 8 to `big_endian` (1 selects big endian), bits 7:5 to `pll_code` (the multiplier minus 2; 7 is reserved), and bits 4:1 to `wb_rate`.
- R5: While `cfg_valid` is high and no new load has started, all fields and `cfg_err` hold their values, and `mode_din` has no effect on them.
- R6: `cfg_err` is 1 after a load if bit 0 is 1, or if any bit from 18 to 255 is 1.
- R7: `cfg_err` is 1 after a load if `pll_code` is 7 or `nbw_type` is 01. It is 0 when R6 and R7 find nothing.
- R8: Asserting and releasing `warm_rst` while `cold_rst` is low leaves `cfg_valid` and every field unchanged.
- R9: `hold_short` sets when `cold_rst` falls before COLD_HOLD clocks have passed since `cfg_valid` rose. It stays 0 if the fall comes later. It is cleared at the start of a load.
- R10: `gap_short` sets when `warm_rst` falls fewer than RST_GAP clocks after `cold_rst` fell, and this includes a fall in the same cycle. It stays 0 for a longer gap and is cleared at the start of a load.
- R11: While `rst` is held, `cfg_valid`, `cfg_err`, `mode_clk`, `hold_short`, `gap_short` and all fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high block reset |
| pwr_good | input | 1 | Power-good; its rising edge starts a load |
| cold_rst | input | 1 | Cold reset, active high |
| warm_rst | input | 1 | Reset input (warm reset), active high |
| mode_din | input | 1 | Serial configuration data |
| mode_clk | output | 1 | Mode clock, master clock / 2^DIV_LOG2 |
| cfg_valid | output | 1 | Configuration loaded and stable |
| cfg_err | output | 1 | Nonzero must-be-zero bit or reserved code |
| wr_delay | output | 3 | Write address-to-data delay in clocks |
| drive_code | output | 2 | Output drive strength code |
| bus_32 | output | 1 | 1 selects a 32-bit system bus |
| timer_int_off | output | 1 | 1 disables the timer interrupt |
| nbw_type | output | 2 | Non-block write type |
| big_endian | output | 1 | 1 selects big-endian byte order |
| pll_code | output | 3 | PLL multiplier minus 2 |
| wb_rate | output | 4 | Block-write data-rate code |
| hold_short | output | 1 | Cold reset released too early |
| gap_short | output | 1 | Warm reset released too soon after cold |

## Verification
The case that needs care is `cold_rst` and `warm_rst` being released on the same clock edge. In that cycle the gap counter restarts and the warm-release check fires, both at once. The bench provokes this by lowering both inputs at the same negative edge. It then expects `gap_short` to be set, because a gap of zero is shorter than RST_GAP. A second pairing is the final sample edge of a load, which coincides with the mode-clock fall. The bench uses each observed fall to drive the next bit, and it checks `cfg_valid` at the negative edges just before and just after the valid register updates.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;
  // Bit positions of the decoded region in the stream
  localparam int CFG_LO   = 1;
  localparam int CFG_HI   = 17;
  localparam int CAP_BITS = CFG_HI + 1;

  localparam logic [1:0] NBW_RSVD = 2'b01;
  localparam logic [2:0] PLL_RSVD = 3'b111;

  // Packed so that it lines up with stream bits 17 down to 1
  typedef struct packed {
    logic [2:0] wr_delay;
    logic [1:0] drive;
    logic       bus32;
    logic       tmr_off;
    logic [1:0] nbw;
    logic       big_end;
    logic [2:0] pll;
    logic [3:0] wb_rate;
  } boot_cfg_t;
endpackage

// File: rtl/mode_clk_gen.sv
module mode_clk_gen #(
  parameter int DIV_LOG2 = 8
) (
  input  logic clk,
  input  logic rst,
  output logic mode_clk_o,
  output logic sample_o
);
  localparam int DIV    = 1 << DIV_LOG2;
  localparam int HALF   = DIV / 2;
  localparam int SAMPLE = DIV - 4;
  localparam int RISE   = HALF - 4;

  logic [DIV_LOG2-1:0] cnt;
  logic                mclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      mclk_q <= 1'b0;
    end else begin
      cnt    <= cnt + 1'b1;
      mclk_q <= (cnt >= DIV_LOG2'(RISE)) && (cnt < DIV_LOG2'(SAMPLE));
    end
  end

  assign sample_o   = (cnt == DIV_LOG2'(SAMPLE));
  assign mode_clk_o = mclk_q;

  // R1: the sample edge is the mode-clock falling edge
  a_r1_fall_at_sample: assert property (@(posedge clk) disable iff (rst)
    sample_o |=> $fell(mode_clk_o));
  // R1: the mode clock never rises on a sample edge
  a_r1_no_rise_at_sample: assert property (@(posedge clk) disable iff (rst)
    sample_o |=> !$rose(mode_clk_o));
endmodule

// File: rtl/stream_shifter.sv
module stream_shifter #(
  parameter int STREAM_BITS = 256,
  parameter int CAP_BITS    = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                sample,
  input  logic                din,
  output logic [CAP_BITS-1:0] cap,
  output logic                hi_nz,
  output logic                done
);
  localparam int IDXW = $clog2(STREAM_BITS);
  localparam int LAST = STREAM_BITS - 1;

  logic [IDXW-1:0] idx;
  logic            loading;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      loading <= 1'b0;
      cap     <= '0;
      hi_nz   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        idx     <= '0;
        loading <= 1'b1;
        cap     <= '0;
        hi_nz   <= 1'b0;
      end else if (loading && sample) begin
        for (int k = 0; k < CAP_BITS; k++) begin
          if (idx == IDXW'(k)) cap[k] <= din;
        end
        if (idx >= IDXW'(CAP_BITS)) hi_nz <= hi_nz | din;
        if (idx == IDXW'(LAST)) begin
          loading <= 1'b0;
          done    <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R2: completion is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2: completion only follows a sampled bit
  a_r2_done_after_sample: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(sample));
endmodule

// File: rtl/cfg_decoder.sv
module cfg_decoder
  import boot_cfg_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                done,
  input  logic [CAP_BITS-1:0] cap,
  input  logic                hi_nz,
  output boot_cfg_t           cfg,
  output logic                valid,
  output logic                err
);
  boot_cfg_t nxt;
  logic      rsvd_hit;

  always_comb begin
    nxt      = boot_cfg_t'(cap[CFG_HI:CFG_LO]);
    rsvd_hit = (nxt.pll == PLL_RSVD) || (nxt.nbw == NBW_RSVD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= '0;
      valid <= 1'b0;
      err   <= 1'b0;
    end else if (start) begin
      valid <= 1'b0;
    end else if (done) begin
      cfg   <= nxt;
      err   <= cap[0] | hi_nz | rsvd_hit;
      valid <= 1'b1;
    end
  end

  // R2: a finished stream yields a valid configuration
  a_r2_valid_after_done: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> valid);
  // R5: fields hold while valid stays high
  a_r5_fields_stable: assert property (@(posedge clk) disable iff (rst)
    (valid && $past(valid)) |-> ($stable(cfg) && $stable(err)));
  // R7: a reserved multiplier code is always flagged
  a_r7_pll_rsvd: assert property (@(posedge clk) disable iff (rst)
    (valid && cfg.pll == PLL_RSVD) |-> err);
  // R7: a reserved write type is always flagged
  a_r7_nbw_rsvd: assert property (@(posedge clk) disable iff (rst)
    (valid && cfg.nbw == NBW_RSVD) |-> err);
endmodule

// File: rtl/rst_seq_monitor.sv
module rst_seq_monitor #(
  parameter int COLD_HOLD = 65536,
  parameter int RST_GAP   = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cfg_valid,
  input  logic cold_rst,
  input  logic warm_rst,
  output logic hold_short,
  output logic gap_short
);
  localparam int HCW = $clog2(COLD_HOLD + 1);
  localparam int GCW = $clog2(RST_GAP + 1);

  logic [HCW-1:0] hold_cnt;
  logic [GCW-1:0] gap_cnt;
  logic           cold_q, warm_q, armed;
  logic           cold_fall, warm_fall;

  assign cold_fall = cold_q & ~cold_rst;
  assign warm_fall = warm_q & ~warm_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      cold_q     <= 1'b0;
      warm_q     <= 1'b0;
      hold_cnt   <= '0;
      gap_cnt    <= '0;
      armed      <= 1'b0;
      hold_short <= 1'b0;
      gap_short  <= 1'b0;
    end else begin
      cold_q <= cold_rst;
      warm_q <= warm_rst;

      if (start || !cfg_valid) hold_cnt <= '0;
      else if (cold_rst && hold_cnt < HCW'(COLD_HOLD)) hold_cnt <= hold_cnt + 1'b1;

      if (cold_fall) gap_cnt <= '0;
      else if (gap_cnt < GCW'(RST_GAP)) gap_cnt <= gap_cnt + 1'b1;

      if (cold_fall) armed <= 1'b1;
      else if (warm_fall) armed <= 1'b0;

      if (start) begin
        hold_short <= 1'b0;
        gap_short  <= 1'b0;
      end else begin
        if (cold_fall && (!cfg_valid || hold_cnt < HCW'(COLD_HOLD)))
          hold_short <= 1'b1;
        if (warm_fall && (cold_rst || cold_fall ||
                          (armed && gap_cnt < GCW'(RST_GAP))))
          gap_short <= 1'b1;
      end
    end
  end

  // R9: the hold flag sets only on a cold-reset release
  a_r9_hold_on_release: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_short) |-> $past(cold_q && !cold_rst));
  // R10: the gap flag sets only on a warm-reset release
  a_r10_gap_on_release: assert property (@(posedge clk) disable iff (rst)
    $rose(gap_short) |-> $past(warm_q && !warm_rst));
  // R10: a same-cycle release of both resets is flagged
  a_r10_same_cycle: assert property (@(posedge clk) disable iff (rst)
    (cold_fall && warm_fall && !start) |=> gap_short);
endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader
  import boot_cfg_pkg::*;
#(
  parameter int DIV_LOG2    = 8,
  parameter int STREAM_BITS = 256,
  parameter int COLD_HOLD   = 65536,
  parameter int RST_GAP     = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_good,
  input  logic       cold_rst,
  input  logic       warm_rst,
  input  logic       mode_din,
  output logic       mode_clk,
  output logic       cfg_valid,
  output logic       cfg_err,
  output logic [2:0] wr_delay,
  output logic [1:0] drive_code,
  output logic       bus_32,
  output logic       timer_int_off,
  output logic [1:0] nbw_type,
  output logic       big_endian,
  output logic [2:0] pll_code,
  output logic [3:0] wb_rate,
  output logic       hold_short,
  output logic       gap_short
);
  logic                pg_q, start, sample, hi_nz, done;
  logic [CAP_BITS-1:0] cap;
  boot_cfg_t           cfg;

  always_ff @(posedge clk) begin
    if (rst) pg_q <= 1'b0;
    else     pg_q <= pwr_good;
  end
  assign start = pwr_good & ~pg_q;

  mode_clk_gen #(.DIV_LOG2(DIV_LOG2)) u_clk (
    .clk(clk), .rst(rst), .mode_clk_o(mode_clk), .sample_o(sample));

  stream_shifter #(.STREAM_BITS(STREAM_BITS), .CAP_BITS(CAP_BITS)) u_shift (
    .clk(clk), .rst(rst), .start(start), .sample(sample), .din(mode_din),
    .cap(cap), .hi_nz(hi_nz), .done(done));

  cfg_decoder u_dec (
    .clk(clk), .rst(rst), .start(start), .done(done), .cap(cap),
    .hi_nz(hi_nz), .cfg(cfg), .valid(cfg_valid), .err(cfg_err));

  rst_seq_monitor #(.COLD_HOLD(COLD_HOLD), .RST_GAP(RST_GAP)) u_mon (
    .clk(clk), .rst(rst), .start(start), .cfg_valid(cfg_valid),
    .cold_rst(cold_rst), .warm_rst(warm_rst),
    .hold_short(hold_short), .gap_short(gap_short));

  assign wr_delay      = cfg.wr_delay;
  assign drive_code    = cfg.drive;
  assign bus_32        = cfg.bus32;
  assign timer_int_off = cfg.tmr_off;
  assign nbw_type      = cfg.nbw;
  assign big_endian    = cfg.big_end;
  assign pll_code      = cfg.pll;
  assign wb_rate       = cfg.wb_rate;

  // R11: nothing is valid straight after reset
  a_r11_reset_clean: assert property (@(posedge clk)
    $past(rst) |-> (!cfg_valid && !cfg_err && !hold_short && !gap_short));
  // R2: a new load drops the valid flag
  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> !cfg_valid);
endmodule

// File: tb/boot_mode_loader_bench.sv
module boot_mode_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DL2        = 4;
  localparam int BITP       = 1 << DL2;
  localparam int HOLD       = 100;
  localparam int GAP        = 10;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0;
  logic rst, pwr_good, cold_rst, warm_rst, mode_din;
  logic mode_clk, cfg_valid, cfg_err, bus_32, timer_int_off, big_endian;
  logic hold_short, gap_short;
  logic [2:0] wr_delay, pll_code;
  logic [1:0] drive_code, nbw_type;
  logic [3:0] wb_rate;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_mode_loader #(.DIV_LOG2(DL2), .STREAM_BITS(256),
                     .COLD_HOLD(HOLD), .RST_GAP(GAP)) u_boot_mode_loader (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .cold_rst(cold_rst),
    .warm_rst(warm_rst), .mode_din(mode_din), .mode_clk(mode_clk),
    .cfg_valid(cfg_valid), .cfg_err(cfg_err), .wr_delay(wr_delay),
    .drive_code(drive_code), .bus_32(bus_32), .timer_int_off(timer_int_off),
    .nbw_type(nbw_type), .big_endian(big_endian), .pll_code(pll_code),
    .wb_rate(wb_rate), .hold_short(hold_short), .gap_short(gap_short));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_err(input logic [255:0] s);
    return s[0] | (|s[255:18]) | (s[7:5] == 3'b111) | (s[10:9] == 2'b01);
  endfunction

  function automatic logic [16:0] pack_fields();
    return {wr_delay, drive_code, bus_32, timer_int_off, nbw_type,
            big_endian, pll_code, wb_rate};
  endfunction

  task automatic wait_fall();
    logic prev;
    prev = mode_clk;
    @(negedge clk);
    while (!(prev && !mode_clk)) begin
      prev = mode_clk;
      @(negedge clk);
    end
  endtask

  task automatic run_load(input logic [255:0] s);
    cold_rst = 1'b1;
    warm_rst = 1'b1;
    pwr_good = 1'b0;
    repeat (3) @(negedge clk);
    wait_fall();
    mode_din = s[0];
    pwr_good = 1'b1;
    for (int i = 1; i < 256; i++) begin
      wait_fall();
      mode_din = s[i];
    end
    wait_fall();
    chk("R2", "valid before update", 32'(cfg_valid), 32'd0);
    @(negedge clk);
    chk("R2", "valid after last bit", 32'(cfg_valid), 32'd1);
  endtask

  task automatic check_fields(input logic [255:0] s);
    chk("R3", "wr_delay", 32'(wr_delay), 32'(s[17:15]));
    chk("R3", "drive_code", 32'(drive_code), 32'(s[14:13]));
    chk("R3", "bus_32", 32'(bus_32), 32'(s[12]));
    chk("R3", "timer_int_off", 32'(timer_int_off), 32'(s[11]));
    chk("R4", "nbw_type", 32'(nbw_type), 32'(s[10:9]));
    chk("R4", "big_endian", 32'(big_endian), 32'(s[8]));
    chk("R4", "pll_code", 32'(pll_code), 32'(s[7:5]));
    chk("R4", "wb_rate", 32'(wb_rate), 32'(s[4:1]));
    chk("R6_R7", "cfg_err", 32'(cfg_err), 32'(exp_err(s)));
  endtask

  function automatic logic [255:0] rand_clean();
    logic [255:0] s;
    s = '0;
    s[17:1] = 17'($urandom);
    if (s[7:5] == 3'b111) s[7:5] = 3'b010;
    if (s[10:9] == 2'b01) s[10:9] = 2'b10;
    return s;
  endfunction

  // release cold after hold_n, then warm after gap_n more cycles
  task automatic release_seq(input int hold_n, input int gap_n);
    repeat (hold_n) @(negedge clk);
    cold_rst = 1'b0;
    if (gap_n == 0) warm_rst = 1'b0;
    else begin
      repeat (gap_n) @(negedge clk);
      warm_rst = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [255:0] s;
    logic [16:0]  snap;
    int rises, highs, t_rise0, t_rise1;
    void'($urandom(32'd4711));
    rst = 1'b1; pwr_good = 1'b0; cold_rst = 1'b1; warm_rst = 1'b1; mode_din = 1'b0;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk("R11", "valid", 32'(cfg_valid), 32'd0);
    chk("R11", "err", 32'(cfg_err), 32'd0);
    chk("R11", "mode_clk", 32'(mode_clk), 32'd0);
    chk("R11", "flags", 32'({hold_short, gap_short}), 32'd0);
    chk("R11", "fields", 32'(pack_fields()), 32'd0);
    rst = 1'b0;

    // R1 mode clock period and high time
    wait_fall();
    rises = 0; highs = 0; t_rise0 = 0; t_rise1 = 0;
    for (int c = 1; c <= 3 * BITP; c++) begin
      logic p;
      p = mode_clk;
      @(negedge clk);
      if (!p && mode_clk) begin
        rises++;
        if (rises == 1) t_rise0 = c;
        if (rises == 2) t_rise1 = c;
      end
      if (rises == 1 && mode_clk) highs++;
    end
    chk("R1", "period", 32'(t_rise1 - t_rise0), 32'(BITP));
    chk("R1", "high time", 32'(highs), 32'(BITP / 2));

    // random clean streams
    for (int n = 0; n < 5; n++) begin
      s = rand_clean();
      run_load(s);
      check_fields(s);
    end

    // R6 directed: bit 0, bit 255, random upper bit
    s = rand_clean(); s[0] = 1'b1;   run_load(s); check_fields(s);
    s = rand_clean(); s[255] = 1'b1; run_load(s); check_fields(s);
    s = rand_clean(); s[18 + ($urandom % 237)] = 1'b1; run_load(s); check_fields(s);
    // R7 directed: reserved multiplier, reserved write type
    s = rand_clean(); s[7:5] = 3'b111; run_load(s); check_fields(s);
    s = rand_clean(); s[10:9] = 2'b01; run_load(s); check_fields(s);

    // R9/R10 good sequence, then R8 warm reset and R5 ignored input
    s = rand_clean();
    run_load(s);
    release_seq(HOLD + 20, GAP + 20);
    chk("R9", "hold_short long", 32'(hold_short), 32'd0);
    chk("R10", "gap_short long", 32'(gap_short), 32'd0);
    snap = pack_fields();
    warm_rst = 1'b1;
    repeat (5) @(negedge clk);
    warm_rst = 1'b0;
    for (int k = 0; k < 4 * BITP; k++) begin
      mode_din = 1'($urandom);
      @(negedge clk);
    end
    chk("R8", "fields after warm", 32'(pack_fields()), 32'(snap));
    chk("R8", "valid after warm", 32'(cfg_valid), 32'd1);
    chk("R5", "fields vs stream", 32'(pack_fields()), 32'(s[17:1]));
    chk("R10", "gap_short warm only", 32'(gap_short), 32'd0);

    // R9 early cold release, R10 short gap
    s = rand_clean();
    run_load(s);
    chk("R9", "hold cleared at load", 32'(hold_short), 32'd0);
    release_seq(20, 3);
    chk("R9", "hold_short early", 32'(hold_short), 32'd1);
    chk("R10", "gap_short short", 32'(gap_short), 32'd1);

    // R10 both resets released in the same cycle
    s = rand_clean();
    run_load(s);
    chk("R10", "gap cleared at load", 32'(gap_short), 32'd0);
    release_seq(HOLD + 20, 0);
    chk("R10", "gap_short same cycle", 32'(gap_short), 32'd1);
    chk("R9", "hold_short same cycle", 32'(hold_short), 32'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule